// File: doc/BRIEF.md
# Condition Predicate Gate

This block decides whether an instruction is allowed to take effect. Each 32-bit instruction carries a 4-bit condition selector in its top nibble. The block evaluates that selector against the four arithmetic status flags (negative, zero, carry, overflow) and produces one execute-enable bit. One selector value means "always execute". Another value is reserved and must never count as a valid condition. For that value the block raises a separate reserved flag, so later decode stages can treat the instruction as invalid.

The evaluation logic is purely combinational. The result sits behind one register stage that moves a valid bit along with it, so the predicate lines up with the next pipeline stage. An instruction written with no condition is encoded with the always selector. The block reads no instruction bit other than the selector nibble.

Top module: `cond_gate`

## Requirements
- R1: The condition selector is taken from `instr[31:28]`. Bits `instr[27:0]` have no effect on `exec_en` or `cond_reserved`.
- R2: Selector 4'h0 executes when Z is 1, and selector 4'h1 executes when Z is 0. The flags port is ordered `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V.
- R3: Selectors 4'h2/4'h3 execute on C=1 / C=0. Selectors 4'h4/4'h5 execute on N=1 / N=0. Selectors 4'h6/4'h7 execute on V=1 / V=0.
- R4: Selector 4'h8 executes when C is 1 and Z is 0. Selector 4'h9 executes when C is 0 or Z is 1.
- R5: Selector 4'hA executes when N equals V. Selector 4'hB executes when N differs from V.
- R6: Selector 4'hC executes when Z is 0 and N equals V. Selector 4'hD executes when Z is 1 or N differs from V.
- R7: Selector 4'hE executes for every flag value and never raises `cond_reserved`. For selectors 4'h0 to 4'hE, `cond_reserved` is 0.
- R8: Selector 4'hF gives `exec_en`=0 and `cond_reserved`=1 for every flag value.
- R9: `out_valid` is 1 exactly one clock after a cycle with `in_valid`=1. The result for that instruction is presented in the same cycle. While `out_valid` is 0, both `exec_en` and `cond_reserved` are 0.
- R10: While `rst_n` is low and after it is released, before any valid input, `out_valid`, `exec_en` and `cond_reserved` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and flags are valid this cycle |
| instr | input | 32 | Instruction word; the top nibble is the condition selector |
| flags | input | 4 | Status flags {N, Z, C, V} |
| out_valid | output | 1 | Registered result is valid |
| exec_en | output | 1 | Instruction may execute |
| cond_reserved | output | 1 | The reserved selector was seen |

## Verification
The only internal state is the single result register. If it holds a wrong valid bit or a wrong predicate, the fault shows at the ports in the very next cycle. It appears as an enable for the wrong selector-and-flag pair, a reserved flag on an ordinary selector, or a result with no matching input. Every selector is driven against all sixteen flag combinations, with random filler in the low instruction bits. An error in a single product term therefore shows up on the first vector that reaches it. Idle gaps between bursts check that no stale enable survives once the valid bit drops.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int SEL_W   = 4;
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int NUM_BASE = NUM_SEL / 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_EQ = 4'h0, SEL_NE = 4'h1, SEL_CS = 4'h2, SEL_CC = 4'h3,
        SEL_MI = 4'h4, SEL_PL = 4'h5, SEL_VS = 4'h6, SEL_VC = 4'h7,
        SEL_HI = 4'h8, SEL_LS = 4'h9, SEL_GE = 4'hA, SEL_LT = 4'hB,
        SEL_GT = 4'hC, SEL_LE = 4'hD, SEL_AL = 4'hE, SEL_NV = 4'hF
    } cond_sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    typedef struct packed {
        logic valid;
        logic exec;
        logic rsv;
    } pred_state_t;

endpackage

// File: rtl/cond_flag_eval.sv
module cond_flag_eval
    import cond_pkg::*;
(
    input  flags_t              flg,
    output logic [NUM_SEL-1:0]  hit
);

    // Each even selector is a positive term; the odd one next to it is its complement.
    logic [NUM_BASE-1:0] base;
    logic                n_eq_v;

    always_comb begin
        n_eq_v  = (flg.neg == flg.ovf);
        base[0] = flg.zero;
        base[1] = flg.carry;
        base[2] = flg.neg;
        base[3] = flg.ovf;
        base[4] = flg.carry & ~flg.zero;
        base[5] = n_eq_v;
        base[6] = ~flg.zero & n_eq_v;
        base[7] = 1'b1;
    end

    for (genvar k = 0; k < NUM_BASE; k++) begin : g_pair
        assign hit[2*k]   = base[k];
        assign hit[2*k+1] = ~base[k];
    end

endmodule

// File: rtl/cond_select.sv
module cond_select
    import cond_pkg::*;
(
    input  logic [NUM_SEL-1:0] hit,
    input  logic [SEL_W-1:0]   sel,
    output logic               exec,
    output logic               rsv
);

    always_comb begin
        rsv  = (sel == SEL_NV);
        exec = hit[sel] & ~rsv;
    end

endmodule

// File: rtl/cond_gate.sv
module cond_gate
    import cond_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int SEL_HI  = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [3:0]         flags,
    output logic               out_valid,
    output logic               exec_en,
    output logic               cond_reserved
);

    localparam int SEL_LO = SEL_HI - SEL_W + 1;

    logic [SEL_W-1:0]   sel;
    flags_t             flg;
    logic [NUM_SEL-1:0] hit;
    logic               exec_c;
    logic               rsv_c;
    logic               unused_low;
    pred_state_t        st_d;
    pred_state_t        st_q;

    assign sel        = instr[SEL_HI:SEL_LO];
    assign flg        = flags_t'(flags);
    assign unused_low = ^instr[SEL_LO-1:0];

    cond_flag_eval u_eval (
        .flg (flg),
        .hit (hit)
    );

    cond_select u_sel (
        .hit  (hit),
        .sel  (sel),
        .exec (exec_c),
        .rsv  (rsv_c)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.exec = exec_c;
            st_d.rsv  = rsv_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.valid;
    assign exec_en       = st_q.exec;
    assign cond_reserved = st_q.rsv;

endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [3:0]  flags,
    input logic        out_valid,
    input logic        exec_en,
    input logic        cond_reserved
);

    AST_RSV_BLOCKS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        cond_reserved |-> !exec_en); // R8

    AST_NV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] == 4'hF) |=> (cond_reserved && !exec_en)); // R8

    AST_AL_EXECUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] == 4'hE) |=> (exec_en && !cond_reserved)); // R7

    AST_EQ_FOLLOWS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] == 4'h0) |=> (exec_en == $past(flags[2]))); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!exec_en && !cond_reserved)); // R9

endmodule

bind cond_gate cond_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .instr         (instr),
    .flags         (flags),
    .out_valid     (out_valid),
    .exec_en       (exec_en),
    .cond_reserved (cond_reserved)
);

// File: tb/cond_gate_test.sv
module cond_gate_test;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [3:0]  flags;
    logic        out_valid;
    logic        exec_en;
    logic        cond_reserved;

    int checks;
    int errors;
    int pending;
    bit finished;

    typedef struct {
        logic       exec;
        logic       rsv;
        logic [3:0] sel;
        logic [3:0] flg;
    } exp_t;

    exp_t sb[$];

    cond_gate uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .instr         (instr),
        .flags         (flags),
        .out_valid     (out_valid),
        .exec_en       (exec_en),
        .cond_reserved (cond_reserved)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Expected predicate worked out from the requirement text, flag order {N,Z,C,V}.
    function automatic logic want_exec(input logic [3:0] s, input logic [3:0] f);
        logic n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (s)
            4'h0: return z;                      // R2
            4'h1: return !z;                     // R2
            4'h2: return c;                      // R3
            4'h3: return !c;                     // R3
            4'h4: return n;                      // R3
            4'h5: return !n;                     // R3
            4'h6: return v;                      // R3
            4'h7: return !v;                     // R3
            4'h8: return c && !z;                // R4
            4'h9: return !c || z;                // R4
            4'hA: return n == v;                 // R5
            4'hB: return n != v;                 // R5
            4'hC: return !z && (n == v);         // R6
            4'hD: return z || (n != v);          // R6
            4'hE: return 1'b1;                   // R7
            default: return 1'b0;                // R8
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] s);
        if (s <= 4'h1) return "R2";
        if (s <= 4'h7) return "R3";
        if (s <= 4'h9) return "R4";
        if (s <= 4'hB) return "R5";
        if (s <= 4'hD) return "R6";
        if (s == 4'hE) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input logic act, input logic expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, expv);
        end
    endtask

    // Driver: drives at the falling edge and queues the expected result.
    task automatic drive(input logic [3:0] s, input logic [3:0] f, input logic [27:0] low);
        exp_t e;
        instr    = {s, low};
        flags    = f;
        in_valid = 1'b1;
        e.exec = want_exec(s, f);
        e.rsv  = (s == 4'hF);
        e.sel  = s;
        e.flg  = f;
        sb.push_back(e);
        pending++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            instr    = $urandom;
            flags    = 4'($urandom);
            @(negedge clk);
        end
    endtask

    // Monitor: samples at the falling edge, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check("R9", out_valid, 1'b0, "out_valid with empty scoreboard");
                    end else begin
                        exp_t e;
                        string r;
                        e = sb.pop_front();
                        pending--;
                        r = req_of(e.sel);
                        check(r, exec_en, e.exec,
                              $sformatf("exec_en sel=%h flags=%b", e.sel, e.flg));
                        check(e.sel == 4'hF ? "R8" : "R7", cond_reserved, e.rsv,
                              $sformatf("cond_reserved sel=%h", e.sel));
                    end
                end else begin
                    check("R9", exec_en, 1'b0, "exec_en while idle");
                    check("R9", cond_reserved, 1'b0, "cond_reserved while idle");
                    if (sb.size() != 0)
                        check("R9", out_valid, 1'b1, "result missing one cycle after input");
                end
            end
        end
    end

    initial begin
        int wd;
        wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        checks   = 0;
        errors   = 0;
        pending  = 0;
        finished = 1'b0;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        instr    = 32'hE000_0000;
        flags    = 4'hF;
        repeat (3) @(negedge clk);
        check("R10", out_valid, 1'b0, "out_valid in reset");
        check("R10", exec_en, 1'b0, "exec_en in reset");
        check("R10", cond_reserved, 1'b0, "cond_reserved in reset");
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R10", out_valid, 1'b0, "out_valid after reset");
        check("R10", exec_en, 1'b0, "exec_en after reset");

        // Exhaustive selector by flag sweep, random low bits (R1).
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                drive(4'(s), 4'(f), 28'($urandom));
            end
            idle(2);
        end

        // R1: same selector and flags, extreme low-bit patterns.
        for (int f = 0; f < 16; f++) begin
            drive(4'h8, 4'(f), 28'h0000000);
            drive(4'h8, 4'(f), 28'hFFFFFFF);
            drive(4'hC, 4'(f), 28'h5555555);
            drive(4'hF, 4'(f), 28'hAAAAAAA);
        end
        idle(1);

        // Mixed back-to-back traffic with gaps.
        for (int i = 0; i < 300; i++) begin
            drive(4'($urandom), 4'($urandom), 28'($urandom));
            if (($urandom % 5) == 0) idle(1);
        end
        idle(3);

        check("R9", (sb.size() == 0) ? 1'b1 : 1'b0, 1'b1, "all queued results delivered");
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule